// File: doc/BRIEF.md
# NAND Read Strobe and Sample Delay Sequencer

This block drives one asynchronous NAND read data cycle at a time. It runs on a tap clock that is `2*TAPS` times faster than the nominal controller clock, so one controller cycle is `SUB = 2*TAPS` ticks. The active-low read strobe `re_n` stays low for the programmed setup cycles and then high for the programmed hold cycles. The pin rate is therefore the controller clock divided by the sum of the two counts. Read data is not taken on the strobe's own edge. It is taken on a feedback point that lies a programmed number of taps after the strobe falls. One tap is an eighth of a reference period. The reference period is either a whole controller cycle or half of one.

The sample delay and the half-period select form the delay-line setting. They may be loaded only while the delay-locked loop (DLL) is off. After the DLL is switched on, no read may start until a fixed settling window of controller cycles has elapsed. A second engine waits for the device's ready line and flags a timeout if ready does not appear in time. The read engine and the wait engine never run together.

Top module: `nand_rd_seq`

## Requirements
- R1: A read requested while `rd_ready` is high makes `re_n` fall at the next clock edge (edge E0). `rd_valid` pulses high for one tick at edge E0+END. END is the larger of (DS+DH)*SUB and S+1. DS and DH are `ds_cyc` and `dh_cyc`, with zero treated as one. S is the sample tick defined in R3 and R4.
- R2: `re_n` stays low for exactly DS*SUB ticks, starting at E0. It is high again no later than the tick in which `rd_valid` pulses.
- R3: When the DLL is on and `cur_delay` is not zero, `rd_data` takes `din` as sampled at edge E0+S, with S = `cur_delay` * step. The step is 2 ticks when `cur_half` is 0 (an eighth of a full reference period) and 1 tick when `cur_half` is 1 (an eighth of a half period).
- R4: When the DLL is off, or when `cur_delay` is 0, the sample tick S equals DS*SUB, which is the rising edge of the strobe.
- R5: When the sample tick lies at or past the end of the strobe cycle, `re_n` stays high until the sample has been taken. Completion then comes at S+1.
- R6: A `cfg_wr` while the DLL is off loads `cfg_delay` and `cfg_half` into `cur_delay` and `cur_half` at the next edge.
- R7: A `cfg_wr` while the DLL is on leaves `cur_delay` and `cur_half` unchanged. It sets `cfg_err`, which stays set until reset.
- R8: `dll_locked` rises 64*SUB ticks after the edge that first sees `dll_en` high. Until then `rd_ready` is low, and `rd_req` does not move `re_n`.
- R9: A ready wait started by `wait_req` with `rb` low throughout sets the sticky `tmo_err` exactly `tmo_cnt`*4096*SUB ticks after its start edge. `wait_busy` drops in the same tick.
- R10: If `rb` is high at an edge during a wait, the wait ends: `rb_done` pulses for one tick, `wait_busy` drops and `tmo_err` is not touched.
- R11: Reads and waits never overlap. A wait request is taken only when no read is active and no read starts in the same tick, so a read wins a tie.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tap clock, SUB ticks per controller cycle |
| rst | input | 1 | Synchronous active-high reset |
| ds_cyc | input | CW | Strobe-low (setup) length in controller cycles |
| dh_cyc | input | CW | Strobe-high (hold) length in controller cycles |
| cfg_wr | input | 1 | Delay-line setting write strobe |
| cfg_delay | input | DW | Sample delay in taps to be written |
| cfg_half | input | 1 | Half-period reference select to be written |
| dll_en | input | 1 | DLL enable level |
| rd_req | input | 1 | Request one read cycle |
| din | input | DATW | Data bus from the device |
| wait_req | input | 1 | Start a ready wait |
| rb | input | 1 | Device ready, high when ready |
| tmo_cnt | input | TW | Timeout in units of 4096 controller cycles |
| re_n | output | 1 | Active-low read strobe |
| rd_data | output | DATW | Captured read data |
| rd_valid | output | 1 | One-tick pulse at the end of a read cycle |
| rd_ready | output | 1 | A read may start now |
| cur_delay | output | DW | Active sample delay in taps |
| cur_half | output | 1 | Active half-period select |
| dll_locked | output | 1 | DLL settling window finished |
| cfg_err | output | 1 | Sticky flag for a rejected setting write |
| wait_busy | output | 1 | Ready wait in progress |
| rb_done | output | 1 | One-tick pulse when ready ends a wait |
| tmo_err | output | 1 | Sticky ready-timeout flag |

## Verification
A tick counter inside the read engine that is off by one shows up within the same read in two ways. The number of low strobe ticks changes, and the `rd_valid` pulse moves, so both are measured against the bench's own counts. A wrong tap step or a wrong half-period choice moves the sample point. Because `din` changes every tick with a known pattern, the captured byte then differs from the expected one on the first read that uses that setting. A faulty settle counter or lock gate shows at once in when `dll_locked` rises and in whether `re_n` moves during the window. A faulty timeout counter shows as a `tmo_err` edge a tick early or late.

// File: rtl/nrs_pkg.sv
package nrs_pkg;

  typedef enum logic {
    RC_IDLE,
    RC_RUN
  } rc_state_t;

  typedef enum logic {
    BW_IDLE,
    BW_WAIT
  } bw_state_t;

endpackage

// File: rtl/nrs_cfg.sv
module nrs_cfg #(
  parameter int DW         = 5,
  parameter int SUB        = 16,
  parameter int SETTLE_CYC = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [DW-1:0] cfg_delay,
  input  logic          cfg_half,
  input  logic          dll_en,
  output logic [DW-1:0] cur_delay,
  output logic          cur_half,
  output logic          dll_on,
  output logic          dll_locked,
  output logic          cfg_err
);
  localparam int SETTLE_TICKS = SETTLE_CYC * SUB;
  localparam int SCW          = $clog2(SETTLE_TICKS + 1);

  logic [SCW-1:0] settle_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_delay  <= '0;
      cur_half   <= 1'b0;
      dll_on     <= 1'b0;
      dll_locked <= 1'b0;
      cfg_err    <= 1'b0;
      settle_cnt <= '0;
    end else begin
      dll_on <= dll_en;
      if (cfg_wr) begin
        if (!dll_on) begin
          cur_delay <= cfg_delay;
          cur_half  <= cfg_half;
        end else begin
          cfg_err <= 1'b1;
        end
      end
      if (!dll_en) begin
        dll_locked <= 1'b0;
      end else if (!dll_on) begin
        settle_cnt <= SCW'(SETTLE_TICKS - 1);
        dll_locked <= 1'b0;
      end else if (!dll_locked) begin
        if (settle_cnt == '0) dll_locked <= 1'b1;
        else settle_cnt <= settle_cnt - SCW'(1);
      end
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (dll_on && $past(dll_on)) |-> ($stable(cur_delay) && $stable(cur_half))); // R7
  AST_CFG_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_err) |-> cfg_err); // R7
  AST_LOCK_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    dll_locked |-> dll_on); // R8

endmodule

// File: rtl/nrs_rdcyc.sv
module nrs_rdcyc
  import nrs_pkg::*;
#(
  parameter int CW   = 4,
  parameter int DW   = 5,
  parameter int DATW = 8,
  parameter int TAPS = 8,
  parameter int SUB  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [CW-1:0]   ds,
  input  logic [CW-1:0]   dh,
  input  logic [DW-1:0]   delay,
  input  logic            half,
  input  logic            dll_act,
  input  logic [DATW-1:0] din,
  output logic            re_n,
  output logic [DATW-1:0] rd_data,
  output logic            rd_valid,
  output logic            active
);
  localparam int STEP_FULL = SUB / TAPS;
  localparam int STEP_HALF = SUB / (2 * TAPS);
  localparam int MAXT      = 2 * ((2 ** CW) - 1) * SUB + ((2 ** DW) - 1) * STEP_FULL + 2;
  localparam int TCW       = $clog2(MAXT + 1);

  rc_state_t      st;
  logic [TCW-1:0] t, low_r, samp_r, end_r;
  logic [TCW-1:0] ds_e, dh_e, low_c, len_c, samp_c, end_c, step_c, t_nx;

  always_comb begin
    ds_e   = (ds == '0) ? TCW'(1) : TCW'(ds);
    dh_e   = (dh == '0) ? TCW'(1) : TCW'(dh);
    low_c  = ds_e * TCW'(SUB);
    len_c  = (ds_e + dh_e) * TCW'(SUB);
    step_c = half ? TCW'(STEP_HALF) : TCW'(STEP_FULL);
    if (dll_act && (delay != '0)) samp_c = TCW'(delay) * step_c;
    else                          samp_c = low_c;
    end_c  = (samp_c + TCW'(1) > len_c) ? samp_c + TCW'(1) : len_c;
    t_nx   = t + TCW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RC_IDLE;
      t        <= '0;
      low_r    <= '0;
      samp_r   <= '0;
      end_r    <= '0;
      re_n     <= 1'b1;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        RC_IDLE: begin
          re_n <= 1'b1;
          if (start) begin
            st     <= RC_RUN;
            t      <= '0;
            re_n   <= 1'b0;
            low_r  <= low_c;
            samp_r <= samp_c;
            end_r  <= end_c;
          end
        end
        default: begin
          t    <= t_nx;
          re_n <= (t_nx < low_r) ? 1'b0 : 1'b1;
          if (t_nx == samp_r) rd_data <= din;
          if (t_nx == end_r) begin
            st       <= RC_IDLE;
            rd_valid <= 1'b1;
            re_n     <= 1'b1;
          end
        end
      endcase
    end
  end

  assign active = (st == RC_RUN);

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R1
  AST_STROBE_HIGH_AT_END: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> re_n); // R2

endmodule

// File: rtl/nrs_rbwait.sv
module nrs_rbwait
  import nrs_pkg::*;
#(
  parameter int TW   = 16,
  parameter int UNIT = 4096,
  parameter int SUB  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          rb,
  input  logic [TW-1:0] tmo_cnt,
  output logic          busy,
  output logic          rb_done,
  output logic          tmo_err
);
  localparam int LW = TW + $clog2(UNIT) + $clog2(SUB) + 1;

  bw_state_t     st;
  logic [LW-1:0] cnt, limit;
  logic [LW-1:0] cnt_nx;

  assign cnt_nx = cnt + LW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= BW_IDLE;
      cnt     <= '0;
      limit   <= '0;
      rb_done <= 1'b0;
      tmo_err <= 1'b0;
    end else begin
      rb_done <= 1'b0;
      case (st)
        BW_IDLE: begin
          if (start) begin
            st    <= BW_WAIT;
            cnt   <= '0;
            limit <= LW'(tmo_cnt) * LW'(UNIT) * LW'(SUB);
          end
        end
        default: begin
          if (rb) begin
            st      <= BW_IDLE;
            rb_done <= 1'b1;
          end else if (cnt_nx >= limit) begin
            st      <= BW_IDLE;
            tmo_err <= 1'b1;
          end else begin
            cnt <= cnt_nx;
          end
        end
      endcase
    end
  end

  assign busy = (st == BW_WAIT);

  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(tmo_err) |-> tmo_err); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    rb_done |-> !busy); // R10

endmodule

// File: rtl/nand_rd_seq.sv
module nand_rd_seq #(
  parameter int CW         = 4,
  parameter int DW         = 5,
  parameter int DATW       = 8,
  parameter int TAPS       = 8,
  parameter int SETTLE_CYC = 64,
  parameter int TMO_UNIT   = 4096,
  parameter int TW         = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CW-1:0]   ds_cyc,
  input  logic [CW-1:0]   dh_cyc,
  input  logic            cfg_wr,
  input  logic [DW-1:0]   cfg_delay,
  input  logic            cfg_half,
  input  logic            dll_en,
  input  logic            rd_req,
  input  logic [DATW-1:0] din,
  input  logic            wait_req,
  input  logic            rb,
  input  logic [TW-1:0]   tmo_cnt,
  output logic            re_n,
  output logic [DATW-1:0] rd_data,
  output logic            rd_valid,
  output logic            rd_ready,
  output logic [DW-1:0]   cur_delay,
  output logic            cur_half,
  output logic            dll_locked,
  output logic            cfg_err,
  output logic            wait_busy,
  output logic            rb_done,
  output logic            tmo_err
);
  localparam int SUB = 2 * TAPS;

  logic dll_on, rd_active, rd_start, wait_start;

  nrs_cfg #(.DW(DW), .SUB(SUB), .SETTLE_CYC(SETTLE_CYC)) u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_delay(cfg_delay),
    .cfg_half(cfg_half), .dll_en(dll_en), .cur_delay(cur_delay),
    .cur_half(cur_half), .dll_on(dll_on), .dll_locked(dll_locked),
    .cfg_err(cfg_err)
  );

  assign rd_ready   = !rd_active && !wait_busy && (!dll_on || dll_locked);
  assign rd_start   = rd_req && rd_ready;
  assign wait_start = wait_req && !rd_active && !wait_busy && !rd_start;

  nrs_rdcyc #(.CW(CW), .DW(DW), .DATW(DATW), .TAPS(TAPS), .SUB(SUB)) u_rd (
    .clk(clk), .rst(rst), .start(rd_start), .ds(ds_cyc), .dh(dh_cyc),
    .delay(cur_delay), .half(cur_half), .dll_act(dll_on), .din(din),
    .re_n(re_n), .rd_data(rd_data), .rd_valid(rd_valid), .active(rd_active)
  );

  nrs_rbwait #(.TW(TW), .UNIT(TMO_UNIT), .SUB(SUB)) u_bw (
    .clk(clk), .rst(rst), .start(wait_start), .rb(rb), .tmo_cnt(tmo_cnt),
    .busy(wait_busy), .rb_done(rb_done), .tmo_err(tmo_err)
  );

  AST_ONE_ENGINE: assert property (@(posedge clk) disable iff (rst)
    !(rd_active && wait_busy)); // R11
  AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
    $fell(re_n) |-> $past(rd_ready)); // R8

endmodule

// File: tb/sim_nand_rd_seq.sv
module sim_nand_rd_seq;
  localparam int CW = 4, DW = 5, DATW = 8, TAPS = 8, TW = 16;
  localparam int SUB = 2 * TAPS;
  localparam int SETTLE = 64 * SUB;

  logic clk = 1'b0, rst = 1'b1;
  logic [CW-1:0] ds_cyc = '0, dh_cyc = '0;
  logic cfg_wr = 1'b0, cfg_half = 1'b0, dll_en = 1'b0, rd_req = 1'b0;
  logic wait_req = 1'b0, rb = 1'b0;
  logic [DW-1:0] cfg_delay = '0;
  logic [TW-1:0] tmo_cnt = '0;
  logic [DATW-1:0] din;
  logic re_n, rd_valid, rd_ready, cur_half, dll_locked, cfg_err;
  logic wait_busy, rb_done, tmo_err;
  logic [DATW-1:0] rd_data;
  logic [DW-1:0] cur_delay;

  int unsigned pcount = 0;
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;
  always @(posedge clk) pcount <= pcount + 1;
  assign din = DATW'(pcount * 37 + 5);

  nand_rd_seq #(.CW(CW), .DW(DW), .DATW(DATW), .TAPS(TAPS), .TW(TW)) u0 (
    .clk(clk), .rst(rst), .ds_cyc(ds_cyc), .dh_cyc(dh_cyc), .cfg_wr(cfg_wr),
    .cfg_delay(cfg_delay), .cfg_half(cfg_half), .dll_en(dll_en),
    .rd_req(rd_req), .din(din), .wait_req(wait_req), .rb(rb),
    .tmo_cnt(tmo_cnt), .re_n(re_n), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .cur_delay(cur_delay), .cur_half(cur_half),
    .dll_locked(dll_locked), .cfg_err(cfg_err), .wait_busy(wait_busy),
    .rb_done(rb_done), .tmo_err(tmo_err)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int f_samp(int ds, int dly, bit hf, bit dll);
    if (dll && dly != 0) return dly * (hf ? 1 : 2);
    return ds * SUB;
  endfunction

  function automatic int f_end(int ds, int dh, int s);
    int len = (ds + dh) * SUB;
    return (s + 1 > len) ? s + 1 : len;
  endfunction

  task automatic wr_cfg(input int d, input bit h);
    cfg_delay = DW'(d); cfg_half = h; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic dll_set(input bit on);
    dll_en = on;
    @(negedge clk);
    if (on) while (!dll_locked) @(negedge clk);
  endtask

  task automatic do_read(input string req, input int ds, input int dh, input bit with_wait);
    int s, e, k, lows;
    int unsigned p0;
    ds_cyc = CW'(ds); dh_cyc = CW'(dh);
    while (!rd_ready) @(negedge clk);
    s = f_samp(ds, cur_delay, cur_half, dll_en);
    e = f_end(ds, dh, s);
    rd_req = 1'b1; wait_req = with_wait;
    @(negedge clk);
    rd_req = 1'b0; wait_req = 1'b0;
    if (with_wait) chk("R11 wait held off by read", wait_busy, 0);
    p0 = pcount; k = 0; lows = 0;
    while (!rd_valid && k < 3000) begin
      if (!re_n) lows++;
      k++;
      @(negedge clk);
    end
    chk({req, " R1 cycle end tick"}, k, e);
    chk({req, " R2 strobe low ticks"}, lows, ds * SUB);
    chk({req, " R3/R4 sampled data"}, rd_data, DATW'((p0 + s - 1) * 37 + 5));
    chk({req, " R2 strobe high at end"}, re_n, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("reset re_n", re_n, 1);
    chk("reset rd_valid", rd_valid, 0);
    chk("reset cfg_err", cfg_err, 0);
    chk("reset tmo_err", tmo_err, 0);
    chk("reset dll_locked", dll_locked, 0);
    chk("reset rd_ready", rd_ready, 1);

    // R6 writes with DLL off
    wr_cfg(0, 0);
    chk("R6 delay load", cur_delay, 0);
    do_read("R4 dll off", 2, 3, 0);
    wr_cfg(5, 1);
    chk("R6 delay load", cur_delay, 5);
    chk("R6 half load", cur_half, 1);
    do_read("R4 dll off with delay set", 2, 1, 0);

    // R8 settle window and blocked reads
    dll_en = 1'b1;
    for (int i = 1; i <= SETTLE; i++) begin
      @(negedge clk);
      if (i == 2) rd_req = 1'b1;
      if (i == 10) begin
        chk("R8 rd_ready low in settle", rd_ready, 0);
        chk("R8 strobe idle in settle", re_n, 1);
      end
      if (i == 11) rd_req = 1'b0;
    end
    chk("R8 not locked early", dll_locked, 0);
    @(negedge clk);
    chk("R8 locked on time", dll_locked, 1);

    do_read("R3 half step", 2, 1, 0);

    // R7 rejected write
    wr_cfg(9, 0);
    chk("R7 delay kept", cur_delay, 5);
    chk("R7 half kept", cur_half, 1);
    chk("R7 cfg_err set", cfg_err, 1);

    // R5 sample past cycle end
    dll_set(0);
    wr_cfg(31, 0);
    dll_set(1);
    do_read("R5 late sample", 1, 1, 0);
    do_read("R11 tie", 1, 2, 1);

    // R10 ready ends wait
    tmo_cnt = 2; wait_req = 1'b1;
    @(negedge clk); wait_req = 1'b0;
    repeat (100) @(negedge clk);
    chk("R10 busy while waiting", wait_busy, 1);
    rb = 1'b1;
    @(negedge clk); rb = 1'b0;
    chk("R10 rb_done", rb_done, 1);
    chk("R10 busy cleared", wait_busy, 0);
    chk("R10 no timeout", tmo_err, 0);

    // R9 timeout
    tmo_cnt = 1; wait_req = 1'b1;
    @(negedge clk); wait_req = 1'b0;
    repeat (4096 * SUB - 1) @(negedge clk);
    chk("R9 no early timeout", tmo_err, 0);
    @(negedge clk);
    chk("R9 timeout on time", tmo_err, 1);
    chk("R9 back to idle", wait_busy, 0);

    // random mix
    for (int it = 0; it < 24; it++) begin
      int d, ds, dh;
      bit h, on;
      d = int'($urandom % 32); h = 1'($urandom % 2); on = 1'($urandom % 2);
      dll_set(0);
      wr_cfg(d, h);
      chk("R6 random delay", cur_delay, d);
      if (on) dll_set(1);
      for (int r = 0; r < 2; r++) begin
        ds = 1 + int'($urandom % 5); dh = 1 + int'($urandom % 5);
        do_read(on ? "R3 random" : "R4 random", ds, dh, 0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule